// File: doc/BRIEF.md
# Clock and Calendar Counter

This block keeps the time of day (seconds, minutes, hours) and a 100-year calendar (weekday, day of month, month, two-digit year). A prescaler counts enable pulses from a 32.768 kHz reference. It advances the counter chain once per second. The chain handles month lengths and February in leap years without help from software. When enabled, it also applies the spring and autumn daylight-saving changes.

A host reads and presets each field through a small register port. Reads are combinational; writes take effect on the clock edge. Two mode inputs choose how field values are coded at the port: BCD or plain binary, and 12-hour or 24-hour hours. The counters inside always hold binary, 24-hour values. A hold input stops all advances so that the host can load a new time without a carry landing between two writes. A one-cycle pulse marks every completed update.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year are 0, and weekday, day of month and month are 1. In BCD 12-hour mode the hour register reads 8'h12.
- R2: One advance happens for every DIV reference pulses. `upd_done` is high for exactly the one cycle in which the new values first appear, and is low at every other time.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R4: The day of month wraps after 30 in months 4, 6, 9 and 11, and after 31 in the other months except 2. Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R5: February has 29 days when the year is divisible by 4, and 28 days otherwise.
- R6: The weekday (1 = Sunday … 7) steps at each midnight and wraps from 7 to 1.
- R7: With `bcd_mode`=1, every field is read and written as two BCD digits (tens in bits 7:4, units in bits 3:0). With `bcd_mode`=0, fields are read and written as plain binary.
- R8: With `hr24`=0, bit 7 of the hour register is the PM flag and bits 6:0 hold 12, 1, …, 11 (12 AM is midnight, 12 PM is noon). With `hr24`=1, the hour register holds 0 to 23.
- R9: With `dst_en`=1, on a Sunday in April with day of month ≤ 7, the time 01:59:59 advances to 03:00:00.
- R10: With `dst_en`=1, on a Sunday in October with day of month ≥ 25, the first pass of 01:59:59 advances to 01:00:00. The next pass advances to 02:00:00. Writing the hour register rearms the repeat.
- R11: While `set_hold`=1, no field advances and `upd_done` stays low, but writes still work. The prescaler restarts, so the first advance after release comes a full DIV pulses later.
- R12: A write at any address in the cycle of an advance takes priority. That second's advance is dropped, and `upd_done` stays low.
- R13: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| set_hold | input | 1 | Freezes all advances while high |
| bcd_mode | input | 1 | 1 = BCD coding at the port, 0 = binary |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables the daylight-saving changes |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data in the selected coding |
| rd_data | output | 8 | Read data for `addr`, combinational |
| upd_done | output | 1 | One-cycle pulse after each completed advance |

## Verification
A write lands on the rising edge where `wr_en` is sampled, and because the read path is combinational, the new value can be read half a cycle later. An advance lands on the edge that samples the DIV-th reference pulse, and `upd_done` rises on that same edge. The bench drives every input on the falling edge and samples on a later falling edge: `upd_done` and the fields are checked one half cycle after the DIV-th pulse. For the hold and write-collision cases, the bench checks that `upd_done` stays low in that same slot.

// File: rtl/rtc_pkg.sv
// Shared types and conversion helpers for the clock/calendar counter.
// Assumes: BCD inputs to bcd2bin hold digits 0-9; binary inputs to bin2bcd are 0-99.
package rtc_pkg;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DOW  = 3'd3,
        F_DOM  = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_NONE = 3'd7
    } field_e;

    typedef struct packed {
        logic [6:0] year;   // 0..99
        logic [3:0] mon;    // 1..12
        logic [4:0] dom;    // 1..31
        logic [2:0] dow;    // 1..7, 1 = Sunday
        logic [4:0] hour;   // 0..23
        logic [5:0] min;    // 0..59
        logic [5:0] sec;    // 0..59
    } tod_t;

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

    // Last day of a month; a year with two low bits zero is divisible by 4.
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the reference enable down to one pulse per DIV reference pulses.
// Assumes: DIV >= 2; hold clears the count so a released hold starts a full period.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic hold,
    output logic sec_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign sec_tick = ref_tick && !hold && (cnt_q == LAST);

    // Count reference pulses, wrapping at LAST, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_chain.sv
// Binary 24-hour counter chain: seconds through year, with leap years and
// optional daylight-saving changes. A write takes priority over an advance.
// Assumes: written values are legal for their field.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       dst_en,
    input  logic       wr_en,
    input  field_e     wr_sel,
    input  logic [6:0] wr_val,
    output tod_t       tod,
    output logic       upd_done
);
    tod_t tod_q;
    tod_t nxt;
    logic rep_q;
    logic rep_n;
    logic step;
    logic spring_day;
    logic fall_day;

    assign step = adv && !wr_en;
    assign tod  = tod_q;

    // Compute the time one second after the current value.
    always_comb begin
        nxt        = tod_q;
        rep_n      = rep_q;
        spring_day = dst_en && tod_q.mon == 4'd4  && tod_q.dow == 3'd1 && tod_q.dom <= 5'd7;
        fall_day   = dst_en && tod_q.mon == 4'd10 && tod_q.dow == 3'd1 && tod_q.dom >= 5'd25;
        if (tod_q.sec != 6'd59) begin
            nxt.sec = tod_q.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (tod_q.min != 6'd59) begin
                nxt.min = tod_q.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (tod_q.hour == 5'd1 && spring_day) begin
                    nxt.hour = 5'd3;
                end else if (tod_q.hour == 5'd1 && fall_day && !rep_q) begin
                    nxt.hour = 5'd1;
                    rep_n    = 1'b1;
                end else if (tod_q.hour == 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.dow  = (tod_q.dow == 3'd7) ? 3'd1 : tod_q.dow + 3'd1;
                    if (tod_q.dom == month_len(tod_q.mon, tod_q.year)) begin
                        nxt.dom = 5'd1;
                        if (tod_q.mon == 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (tod_q.year == 7'd99) ? 7'd0 : tod_q.year + 7'd1;
                        end else begin
                            nxt.mon = tod_q.mon + 4'd1;
                        end
                    end else begin
                        nxt.dom = tod_q.dom + 5'd1;
                    end
                end else begin
                    nxt.hour = tod_q.hour + 5'd1;
                    if (tod_q.hour == 5'd1) rep_n = 1'b0;
                end
            end
        end
    end

    // Apply a host write or a one-second step, and flag completed steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q    <= '{year: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                          hour: 5'd0, min: 6'd0, sec: 6'd0};
            rep_q    <= 1'b0;
            upd_done <= 1'b0;
        end else begin
            upd_done <= step;
            if (wr_en) begin
                case (wr_sel)
                    F_SEC:   tod_q.sec  <= wr_val[5:0];
                    F_MIN:   tod_q.min  <= wr_val[5:0];
                    F_HOUR:  begin
                        tod_q.hour <= wr_val[4:0];
                        rep_q      <= 1'b0;
                    end
                    F_DOW:   tod_q.dow  <= wr_val[2:0];
                    F_DOM:   tod_q.dom  <= wr_val[4:0];
                    F_MON:   tod_q.mon  <= wr_val[3:0];
                    F_YEAR:  tod_q.year <= wr_val;
                    default: ;
                endcase
            end else if (step) begin
                tod_q <= nxt;
                rep_q <= rep_n;
            end
        end
    end
endmodule

// File: rtl/rtc_regport.sv
// Translates between the binary 24-hour counters and the host coding
// (BCD or binary, 12- or 24-hour). Purely combinational.
// Assumes: host data is legal for the selected coding.
module rtc_regport
    import rtc_pkg::*;
(
    input  logic       bcd_mode,
    input  logic       hr24,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    input  tod_t       tod,
    output logic [6:0] wr_val,
    output logic [7:0] rd_data
);
    logic [6:0] plain;
    logic [6:0] wh12;
    logic [6:0] wbase;
    logic [6:0] hmod;
    logic [6:0] rh12;
    logic [6:0] val;
    logic [7:0] enc;
    logic       is_hour;
    logic       pm;

    assign is_hour = (addr == 3'd2);
    assign pm      = (tod.hour >= 5'd12);

    // Decode host write data into a binary 24-hour value.
    always_comb begin
        plain = bcd_mode ? bcd2bin(wr_data) : wr_data[6:0];
        wh12  = bcd_mode ? bcd2bin({1'b0, wr_data[6:0]}) : wr_data[6:0];
        wbase = (wh12 == 7'd12) ? 7'd0 : wh12;
        if (is_hour && !hr24) wr_val = wbase + (wr_data[7] ? 7'd12 : 7'd0);
        else                  wr_val = plain;
    end

    // Encode the addressed field into the host coding.
    always_comb begin
        hmod = pm ? {2'b00, tod.hour} - 7'd12 : {2'b00, tod.hour};
        rh12 = (hmod == 7'd0) ? 7'd12 : hmod;
        case (addr)
            3'd0:    val = {1'b0, tod.sec};
            3'd1:    val = {1'b0, tod.min};
            3'd2:    val = hr24 ? {2'b00, tod.hour} : rh12;
            3'd3:    val = {4'b0000, tod.dow};
            3'd4:    val = {2'b00, tod.dom};
            3'd5:    val = {3'b000, tod.mon};
            3'd6:    val = tod.year;
            default: val = 7'd0;
        endcase
        enc = bcd_mode ? bin2bcd(val) : {1'b0, val};
        if (is_hour && !hr24) rd_data = {pm, enc[6:0]};
        else                  rd_data = enc;
    end
endmodule

// File: rtl/rtc_calendar.sv
// Top of the clock/calendar counter: prescaler, counter chain and host port.
// Assumes: ref_tick is a one-cycle enable synchronous to clk.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       set_hold,
    input  logic       bcd_mode,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       upd_done
);
    logic       sec_tick;
    logic [6:0] wr_val;
    tod_t       tod;

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .hold     (set_hold),
        .sec_tick (sec_tick)
    );

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (sec_tick),
        .dst_en   (dst_en),
        .wr_en    (wr_en),
        .wr_sel   (field_e'(addr)),
        .wr_val   (wr_val),
        .tod      (tod),
        .upd_done (upd_done)
    );

    rtc_regport u_port (
        .bcd_mode (bcd_mode),
        .hr24     (hr24),
        .addr     (addr),
        .wr_data  (wr_data),
        .tod      (tod),
        .wr_val   (wr_val),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/rtc_calendar_chk.sv
// Assertion checker for rtc_calendar, attached by bind below.
// Assumes: DIV >= 2, so two advances never fall on adjacent cycles.
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic wr_en,
    input logic set_hold,
    input logic upd_done,
    input tod_t tod
);
    p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    p_upd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $past(sec_tick && !wr_en));

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && tod.sec == 6'd59) |=> tod.sec == 6'd0);

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && tod.sec != 6'd59) |=> tod.sec == $past(tod.sec) + 6'd1);

    p_leap_day_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && tod.mon == 4'd2 && tod.dom == 5'd28 && tod.year[1:0] == 2'b00
         && tod.hour == 5'd23 && tod.min == 6'd59 && tod.sec == 6'd59) |=> tod.dom == 5'd29);

    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !wr_en) |=> ($stable(tod) && !upd_done));

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sec_tick) |=> !upd_done);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .wr_en    (wr_en),
    .set_hold (set_hold),
    .upd_done (upd_done),
    .tod      (tod)
);

// File: tb/rtc_calendar_tb.sv
// Self-checking bench: directed corner cases plus seeded random one-second steps.
module rtc_calendar_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       set_hold = 1'b0;
    logic       bcd_mode = 1'b1;
    logic       hr24 = 1'b0;
    logic       dst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       upd_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int seed    = 20240;

    // Bench model of the time, binary 24-hour.
    int ms, mm, mh, mdw, md, mmo, my;
    bit mrep;

    rtc_calendar #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .set_hold(set_hold),
        .bcd_mode(bcd_mode), .hr24(hr24), .dst_en(dst_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .upd_done(upd_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 3'(a);
        #1 v = int'(rd_data);
    endtask

    // Give DIV reference pulses; the caller sees upd_done in the returned slot.
    task automatic one_second();
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
        end
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    function automatic int mlen(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        bit spring, fall;
        spring = dst_en && mmo == 4 && mdw == 1 && md <= 7;
        fall   = dst_en && mmo == 10 && mdw == 1 && md >= 25;
        ms++;
        if (ms < 60) return;
        ms = 0; mm++;
        if (mm < 60) return;
        mm = 0;
        if (mh == 1 && spring) begin mh = 3; return; end
        if (mh == 1 && fall && !mrep) begin mrep = 1'b1; return; end
        if (mh == 1) mrep = 1'b0;
        mh++;
        if (mh < 24) return;
        mh = 0;
        mdw = (mdw % 7) + 1;
        md++;
        if (md <= mlen(mmo, my)) return;
        md = 1; mmo++;
        if (mmo <= 12) return;
        mmo = 1; my = (my + 1) % 100;
    endtask

    // Binary 24-hour load of every field into DUT and model.
    task automatic load_all(input int s, input int m, input int h, input int dw,
                            input int d, input int mo, input int y);
        bcd_mode = 1'b0; hr24 = 1'b1;
        wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, d); wr(5, mo); wr(6, y);
        ms = s; mm = m; mh = h; mdw = dw; md = d; mmo = mo; my = y; mrep = 1'b0;
    endtask

    task automatic compare_all(input string req);
        int v;
        rd(0, v); check(req, v, ms);
        rd(1, v); check(req, v, mm);
        rd(2, v); check(req, v, mh);
        rd(3, v); check(req, v, mdw);
        rd(4, v); check(req, v, md);
        rd(5, v); check(req, v, mmo);
        rd(6, v); check(req, v, my);
    endtask

    task automatic step_and_check(input string req);
        one_second();
        check({req, " upd_done"}, int'(upd_done), 1);
        model_step();
        compare_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R8: reset state read in BCD 12-hour coding.
        rd(2, v); check("R1 hour 12AM", v, 8'h12);
        rd(0, v); check("R1 sec", v, 0);
        rd(3, v); check("R1 dow", v, 1);
        rd(4, v); check("R1 dom", v, 1);
        rd(5, v); check("R1 mon", v, 1);
        rd(6, v); check("R1 year", v, 0);
        rd(7, v); check("R13 addr7", v, 0);

        // R7: BCD write read back in binary and BCD; binary write read as BCD.
        bcd_mode = 1'b1; wr(0, 8'h45);
        bcd_mode = 1'b0; rd(0, v); check("R7 bcd->bin", v, 45);
        bcd_mode = 1'b1; rd(0, v); check("R7 bcd read", v, 8'h45);
        bcd_mode = 1'b0; wr(6, 37);
        bcd_mode = 1'b1; rd(6, v); check("R7 bin->bcd", v, 8'h37);

        // R8: 12/24-hour conversion both ways.
        bcd_mode = 1'b0; hr24 = 1'b1; wr(2, 15);
        bcd_mode = 1'b1; hr24 = 1'b0; rd(2, v); check("R8 15h as 12h", v, 8'h83);
        wr(2, 8'h12);
        bcd_mode = 1'b0; hr24 = 1'b1; rd(2, v); check("R8 12AM", v, 0);
        bcd_mode = 1'b1; hr24 = 1'b0; wr(2, 8'h92);
        bcd_mode = 1'b0; hr24 = 1'b1; rd(2, v); check("R8 12PM", v, 12);
        hr24 = 1'b0; rd(2, v); check("R8 bin 12PM", v, 8'h8C);

        // R2: upd_done timing around the DIV-th reference pulse.
        load_all(10, 0, 5, 2, 3, 3, 20);
        for (int i = 0; i < DIV - 1; i++) begin
            @(negedge clk); ref_tick = 1'b1;
        end
        @(negedge clk); check("R2 no early pulse", int'(upd_done), 0);
        ref_tick = 1'b0;
        @(negedge clk); check("R2 held between pulses", int'(upd_done), 0);
        ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        check("R2 pulse", int'(upd_done), 1);
        model_step();
        @(negedge clk); check("R2 single cycle", int'(upd_done), 0);
        compare_all("R2 advance");

        // R3, R4, R6: full rollover at the end of the century.
        load_all(59, 59, 23, 7, 31, 12, 99);
        step_and_check("R3 R4 R6 rollover");
        load_all(59, 59, 23, 3, 30, 4, 10);
        step_and_check("R4 30-day month");
        load_all(59, 59, 23, 3, 30, 5, 10);
        step_and_check("R4 31-day month");

        // R5: leap and common Februaries.
        load_all(59, 59, 23, 2, 28, 2, 24);
        step_and_check("R5 leap 28->29");
        load_all(59, 59, 23, 2, 29, 2, 24);
        step_and_check("R5 leap 29->1");
        load_all(59, 59, 23, 2, 28, 2, 25);
        step_and_check("R5 common 28->1");

        // R9: spring change, with and without dst_en.
        dst_en = 1'b1;
        load_all(59, 59, 1, 1, 5, 4, 30);
        step_and_check("R9 spring");
        rd(2, v); check("R9 hour 3", v, 3);
        dst_en = 1'b0;
        load_all(59, 59, 1, 1, 5, 4, 30);
        step_and_check("R9 off");

        // R10: autumn repeat happens once, then passes to 02.
        dst_en = 1'b1;
        load_all(59, 59, 1, 1, 27, 10, 30);
        step_and_check("R10 repeat");
        rd(2, v); check("R10 hour 1", v, 1);
        wr(1, 59); wr(0, 59); mm = 59; ms = 59;
        step_and_check("R10 second pass");
        rd(2, v); check("R10 hour 2", v, 2);
        dst_en = 1'b0;

        // R11: hold blocks advances; writes still land.
        load_all(20, 0, 8, 4, 10, 6, 40);
        @(negedge clk); set_hold = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            check("R11 no pulse", int'(upd_done), 0);
        end
        @(negedge clk); ref_tick = 1'b0;
        wr(1, 33); mm = 33;
        compare_all("R11 frozen");
        set_hold = 1'b0;
        step_and_check("R11 released");

        // R12: write in the advance cycle wins; second is dropped.
        load_all(30, 10, 9, 5, 11, 7, 41);
        for (int i = 0; i < DIV - 1; i++) begin
            @(negedge clk); ref_tick = 1'b1;
        end
        @(negedge clk); wr_en = 1'b1; addr = 3'd1; wr_data = 8'd44;
        @(negedge clk); wr_en = 1'b0; ref_tick = 1'b0;
        check("R12 no pulse", int'(upd_done), 0);
        mm = 44;
        compare_all("R12 write wins");
        step_and_check("R12 realigned");

        // Random one-second steps near carries, R3 to R10.
        v = int'($urandom(seed));
        for (int it = 0; it < 150; it++) begin
            int s, m, h, dw, d, mo, y;
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 100);
            d  = 1 + int'($urandom % 31);
            if (d > mlen(mo, y)) d = mlen(mo, y);
            if ($urandom % 3 == 0) d = mlen(mo, y);
            dw = 1 + int'($urandom % 7);
            s  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            m  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            if ($urandom % 5 == 0) begin
                mo = ($urandom % 2 == 0) ? 4 : 10;
                d  = (mo == 4) ? 1 + int'($urandom % 7) : 25 + int'($urandom % 7);
                dw = 1; h = 1; m = 59; s = 59;
            end
            dst_en = 1'($urandom % 2);
            load_all(s, m, h, dw, d, mo, y);
            step_and_check("R3-R10 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule